// File: doc/BRIEF.md
# Recency-Protected Eviction Victim Selector

This block picks the fast-tier (DRAM) frame to push out to the slow tier when a migration needs a free fast frame and none is left. Candidate frames come from a pseudo-random walk over the frame space. The walk is driven by a maximal-length LFSR, and its position is kept from one request to the next. For each candidate, the block reads the frame's resident page number and its cold/hot flag through an external page-table port. It accepts the first candidate that is cold and whose page is not marked as recently used.

Recency is tracked by a Bloom filter. Every observed memory access inserts its page number into the filter. A candidate whose page tests positive is protected from eviction. The filter is cleared as a whole after a fixed number of insertions, which keeps its false-positive rate bounded. A search looks at no more than a fixed number of candidates. When no candidate qualifies, the block returns the last frame it looked at. Moving the data and rewriting the page table are left to other blocks.

Top module: `victim_selector`

## Requirements
- R1: After reset, `req_ready` is 1, `vic_valid` is 0 and `meta_req` is 0. The walk register holds the value 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From that edge until the result is presented, `req_ready` is 0 and `meta_req` is 1. `req_ready` returns to 1 in the cycle that `vic_valid` is high.
- R3: The walk register is S = clog2(NUM_FRAMES+1) bits wide. Each step it shifts left by one, and the new bit 0 is the XOR of the register bits selected by a fixed primitive tap mask. For 3 bits the mask is bits 2 and 1. The register starts at 1 and never holds 0. The candidate frame is (state - 1) mod NUM_FRAMES. The walk advances once per candidate and continues across requests.
- R4: During each search cycle, `meta_req` is 1 and `meta_frame` carries exactly one candidate, always below NUM_FRAMES. `meta_page` and `meta_cold` are used in that same cycle.
- R5: A candidate qualifies when `meta_cold` is 1 and its page is not in the filter. The first qualifying candidate ends the search. The result appears on `vic_frame` one cycle after that candidate was presented, so k candidates take k cycles.
- R6: A page inserted through `obs_valid`/`obs_page` is visible to lookups from the next cycle. A cold candidate whose page hits is skipped.
- R7: Let fold(x) be the XOR of consecutive 10-bit slices of x (for a 1024-bit filter), starting at bit 0, with the top slice zero-padded. Index one is fold(page). Index two is fold((page × HASH_MULT) mod 2^PAGE_W). A page hits when both of its bits are set.
- R8: The insertion that brings the count to FILTER_LIMIT (128) clears the whole filter instead of setting bits, and restarts the count at zero.
- R9: When MAX_PROBES (16) candidates have been examined and none qualified, the last one examined is returned.
- R10: `vic_valid` is a single-cycle pulse, and `vic_frame` is below NUM_FRAMES whenever it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| obs_valid | input | 1 | An access was observed this cycle |
| obs_page | input | PAGE_W | Page number of the observed access |
| req_valid | input | 1 | A victim is wanted |
| req_ready | output | 1 | Selector is idle and can take a request |
| meta_req | output | 1 | Candidate lookup active this cycle |
| meta_frame | output | clog2(NUM_FRAMES) | Candidate frame being looked up |
| meta_page | input | PAGE_W | Page resident in `meta_frame` |
| meta_cold | input | 1 | Resident page is cold |
| vic_valid | output | 1 | Result pulse |
| vic_frame | output | clog2(NUM_FRAMES) | Chosen victim frame |

## Verification
The bench builds the block with 7 frames and 12-bit page numbers, and keeps the default 1024-bit filter, the 128-insertion limit and the 16-candidate limit. With 7 frames the 3-bit walk visits every frame once per period, so all 128 cold/hot patterns can be swept and every protected subset of resident pages can be tried. The 16-candidate limit spans more than two full periods of the walk, which makes the fallback reachable. The filter clear is reached with exactly 127 and then 128 insertions.

// File: rtl/vs_pkg.sv
// Package for the eviction victim selector.
// Holds the search state encoding and the primitive tap masks for the
// pseudo-random frame walk. Assumes walk widths from 2 to 16 bits.
package vs_pkg;

    typedef enum logic {
        SRCH_IDLE = 1'b0,
        SRCH_SCAN = 1'b1
    } srch_state_e;

    // Tap mask of a maximal-length shift-left LFSR of the given width (bit k-1 = tap k).
    function automatic logic [15:0] lfsr_tap_mask(input int width);
        case (width)
            2:       return 16'h0003;
            3:       return 16'h0006;
            4:       return 16'h000C;
            5:       return 16'h0014;
            6:       return 16'h0030;
            7:       return 16'h0060;
            8:       return 16'h00B8;
            9:       return 16'h0110;
            10:      return 16'h0240;
            11:      return 16'h0500;
            12:      return 16'h0829;
            13:      return 16'h100D;
            14:      return 16'h2015;
            15:      return 16'h6000;
            16:      return 16'hD008;
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/vs_scan_lfsr.sv
// Pseudo-random frame pointer.
// A maximal-length LFSR of LFSR_W bits steps once per step_i. Its value,
// minus one and reduced modulo NUM_FRAMES, names the current candidate
// frame. Assumes NUM_FRAMES <= 2**LFSR_W - 1 and 2 <= LFSR_W <= 16.
module vs_scan_lfsr #(
    parameter int NUM_FRAMES = 4095,
    parameter int LFSR_W     = 12,
    parameter int FRAME_W    = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_i,
    output logic [FRAME_W-1:0] frame_o
);

    localparam logic [LFSR_W-1:0] TAPS = LFSR_W'(vs_pkg::lfsr_tap_mask(LFSR_W));
    localparam logic [LFSR_W-1:0] SEED = LFSR_W'(1);

    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] state_nxt;

    // Next walk value, forced back to the seed should it ever reach zero.
    always_comb begin
        state_nxt = {state_q[LFSR_W-2:0], ^(state_q & TAPS)};
        if (state_nxt == '0) begin
            state_nxt = SEED;
        end
    end

    // Walk register: seeded on reset, advanced once per examined candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (step_i) begin
            state_q <= state_nxt;
        end
    end

    assign frame_o = FRAME_W'((32'(state_q) - 32'd1) % NUM_FRAMES);

endmodule

// File: rtl/vs_recency_filter.sv
// Bloom filter of recently accessed pages.
// Two hashes per page: an XOR fold of the page number, and an XOR fold of
// the page number times an odd constant. Inserts land one cycle after
// ins_valid_i. The insertion that would be number FILTER_LIMIT clears the
// array instead. Assumes FILTER_BITS is a power of two.
module vs_recency_filter #(
    parameter int          PAGE_W       = 20,
    parameter int          FILTER_BITS  = 1024,
    parameter int          FILTER_LIMIT = 128,
    parameter logic [31:0] HASH_MULT    = 32'h9E3779B1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid_i,
    input  logic [PAGE_W-1:0] ins_page_i,
    input  logic [PAGE_W-1:0] look_page_i,
    output logic              hit_o
);

    localparam int IDX_W  = $clog2(FILTER_BITS);
    localparam int NCHUNK = (PAGE_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = NCHUNK * IDX_W;
    localparam int CNT_W  = $clog2(FILTER_LIMIT + 1);
    localparam logic [PAGE_W-1:0] MULT  = PAGE_W'(HASH_MULT);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(FILTER_LIMIT - 1);

    logic [FILTER_BITS-1:0] bits_q;
    logic [CNT_W-1:0]       count_q;
    logic [IDX_W-1:0]       ins_h1, ins_h2, look_h1, look_h2;

    // XOR-fold a page-wide value down to a filter index.
    function automatic logic [IDX_W-1:0] fold_idx(input logic [PAGE_W-1:0] v);
        logic [PAD_W-1:0] padded;
        logic [IDX_W-1:0] acc;
        padded = PAD_W'(v);
        acc    = '0;
        for (int i = 0; i < NCHUNK; i++) begin
            acc = acc ^ padded[i*IDX_W +: IDX_W];
        end
        return acc;
    endfunction

    // Second hash: scramble by an odd multiplier, then fold.
    function automatic logic [IDX_W-1:0] mix_idx(input logic [PAGE_W-1:0] v);
        logic [PAGE_W-1:0] scrambled;
        scrambled = v * MULT;
        return fold_idx(scrambled);
    endfunction

    // Hash both the inserted page and the looked-up page.
    always_comb begin
        ins_h1  = fold_idx(ins_page_i);
        ins_h2  = mix_idx(ins_page_i);
        look_h1 = fold_idx(look_page_i);
        look_h2 = mix_idx(look_page_i);
    end

    // Filter array and insert counter: set two bits per insert, wipe at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q  <= '0;
            count_q <= '0;
        end else if (ins_valid_i) begin
            if (count_q == LAST) begin
                bits_q  <= '0;
                count_q <= '0;
            end else begin
                bits_q[ins_h1] <= 1'b1;
                bits_q[ins_h2] <= 1'b1;
                count_q        <= count_q + 1'b1;
            end
        end
    end

    assign hit_o = bits_q[look_h1] & bits_q[look_h2];

endmodule

// File: rtl/vs_search_ctrl.sv
// Search sequencer.
// Accepts a request while idle, then examines one candidate per cycle.
// It stops at the first qualifying candidate or at candidate MAX_PROBES,
// and registers the chosen frame as a one-cycle result pulse. Assumes the
// candidate and its qualification are valid in every scan cycle.
module vs_search_ctrl #(
    parameter int MAX_PROBES = 16,
    parameter int FRAME_W    = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    output logic               req_ready_o,
    input  logic [FRAME_W-1:0] cand_frame_i,
    input  logic               cand_ok_i,
    output logic               scan_o,
    output logic               vic_valid_o,
    output logic [FRAME_W-1:0] vic_frame_o
);

    import vs_pkg::*;

    localparam int PROBE_W = (MAX_PROBES > 1) ? $clog2(MAX_PROBES) : 1;
    localparam logic [PROBE_W-1:0] LAST_PROBE = PROBE_W'(MAX_PROBES - 1);

    srch_state_e         state_q;
    logic [PROBE_W-1:0]  probe_q;
    logic                take;

    assign scan_o      = (state_q == SRCH_SCAN);
    assign req_ready_o = (state_q == SRCH_IDLE);
    assign take        = scan_o && (cand_ok_i || (probe_q == LAST_PROBE));

    // State and probe counter: idle until a request, scan until a take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SRCH_IDLE;
            probe_q <= '0;
        end else begin
            case (state_q)
                SRCH_IDLE: begin
                    probe_q <= '0;
                    if (req_valid_i) begin
                        state_q <= SRCH_SCAN;
                    end
                end
                SRCH_SCAN: begin
                    if (take) begin
                        state_q <= SRCH_IDLE;
                        probe_q <= '0;
                    end else begin
                        probe_q <= probe_q + 1'b1;
                    end
                end
                default: state_q <= SRCH_IDLE;
            endcase
        end
    end

    // Result register: pulse valid for one cycle and hold the chosen frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vic_valid_o <= 1'b0;
            vic_frame_o <= '0;
        end else begin
            vic_valid_o <= take;
            if (take) begin
                vic_frame_o <= cand_frame_i;
            end
        end
    end

endmodule

// File: rtl/victim_selector.sv
// Recency-protected eviction victim selector (top).
// Ties the pseudo-random frame walk, the recency Bloom filter and the
// search sequencer together. The page-table port is read combinationally:
// meta_page and meta_cold must answer meta_frame within the same cycle.
module victim_selector #(
    parameter int          NUM_FRAMES   = 4095,
    parameter int          PAGE_W       = 20,
    parameter int          FILTER_BITS  = 1024,
    parameter int          FILTER_LIMIT = 128,
    parameter int          MAX_PROBES   = 16,
    parameter logic [31:0] HASH_MULT    = 32'h9E3779B1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          obs_valid,
    input  logic [PAGE_W-1:0]             obs_page,
    input  logic                          req_valid,
    output logic                          req_ready,
    output logic                          meta_req,
    output logic [$clog2(NUM_FRAMES)-1:0] meta_frame,
    input  logic [PAGE_W-1:0]             meta_page,
    input  logic                          meta_cold,
    output logic                          vic_valid,
    output logic [$clog2(NUM_FRAMES)-1:0] vic_frame
);

    localparam int FRAME_W = $clog2(NUM_FRAMES);
    localparam int LFSR_W  = $clog2(NUM_FRAMES + 1);

    logic               scan;
    logic               protect_hit;
    logic               cand_ok;
    logic [FRAME_W-1:0] cand_frame;

    vs_scan_lfsr #(
        .NUM_FRAMES (NUM_FRAMES),
        .LFSR_W     (LFSR_W),
        .FRAME_W    (FRAME_W)
    ) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (scan),
        .frame_o (cand_frame)
    );

    vs_recency_filter #(
        .PAGE_W       (PAGE_W),
        .FILTER_BITS  (FILTER_BITS),
        .FILTER_LIMIT (FILTER_LIMIT),
        .HASH_MULT    (HASH_MULT)
    ) u_recent (
        .clk         (clk),
        .rst_n       (rst_n),
        .ins_valid_i (obs_valid),
        .ins_page_i  (obs_page),
        .look_page_i (meta_page),
        .hit_o       (protect_hit)
    );

    assign cand_ok = meta_cold & ~protect_hit;

    vs_search_ctrl #(
        .MAX_PROBES (MAX_PROBES),
        .FRAME_W    (FRAME_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid),
        .req_ready_o  (req_ready),
        .cand_frame_i (cand_frame),
        .cand_ok_i    (cand_ok),
        .scan_o       (scan),
        .vic_valid_o  (vic_valid),
        .vic_frame_o  (vic_frame)
    );

    assign meta_req   = scan;
    assign meta_frame = cand_frame;

endmodule

// File: rtl/vs_checker.sv
// Property checker for the victim selector, attached by bind.
// Watches only the top-level ports and keeps a count of consecutive
// lookup cycles, which bounds the search and identifies the last probe.
module vs_checker #(
    parameter int NUM_FRAMES = 4095,
    parameter int MAX_PROBES = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic                          req_ready,
    input logic                          meta_req,
    input logic [$clog2(NUM_FRAMES)-1:0] meta_frame,
    input logic                          meta_cold,
    input logic                          vic_valid,
    input logic [$clog2(NUM_FRAMES)-1:0] vic_frame
);

    int run_q;

    // Count lookup cycles since the search began.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 0;
        end else begin
            run_q <= meta_req ? run_q + 1 : 0;
        end
    end

    AST_ACCEPT_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> meta_req); // R2

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        meta_req |-> !req_ready); // R2

    AST_RESULT_ENDS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |-> (!meta_req && req_ready)); // R2

    AST_META_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        meta_req |-> (int'(meta_frame) < NUM_FRAMES)); // R4

    AST_VIC_FROM_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |-> ($past(meta_req) && vic_frame == $past(meta_frame))); // R5

    AST_EARLY_IS_COLD: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_valid && $past(run_q) != MAX_PROBES - 1) |-> $past(meta_cold)); // R5

    AST_PROBE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        meta_req |-> (run_q < MAX_PROBES)); // R9

    AST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |=> !vic_valid); // R10

    AST_VIC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |-> (int'(vic_frame) < NUM_FRAMES)); // R10

    // With a full-period walk over all frames, consecutive candidates always differ.
    if (NUM_FRAMES == (1 << $clog2(NUM_FRAMES + 1)) - 1) begin : g_full_walk
        AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
            (meta_req && $past(meta_req)) |-> (meta_frame != $past(meta_frame))); // R3
    end

endmodule

bind victim_selector vs_checker #(
    .NUM_FRAMES (NUM_FRAMES),
    .MAX_PROBES (MAX_PROBES)
) u_vs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .meta_req   (meta_req),
    .meta_frame (meta_frame),
    .meta_cold  (meta_cold),
    .vic_valid  (vic_valid),
    .vic_frame  (vic_frame)
);

// File: tb/victim_selector_test.sv
// Bench for the victim selector: 7 frames, 12-bit pages, default filter.
// A behavioural model of the walk and the filter, written from the
// requirements, predicts every candidate, the victim and the latency.
`timescale 1ns/1ps
module victim_selector_test;

    localparam int NF = 7;
    localparam int PW = 12;
    localparam int MP = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          obs_valid;
    logic [PW-1:0] obs_page;
    logic          req_valid;
    logic          req_ready;
    logic          meta_req;
    logic [2:0]    meta_frame;
    logic [PW-1:0] meta_page;
    logic          meta_cold;
    logic          vic_valid;
    logic [2:0]    vic_frame;

    logic [PW-1:0] pg [0:7];
    logic [7:0]    cold;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state
    logic [2:0]  ms;
    bit [1023:0] mb;
    int          mcnt;

    always #10 clk = ~clk;

    assign meta_page = pg[meta_frame];
    assign meta_cold = cold[meta_frame];

    victim_selector #(
        .NUM_FRAMES (NF),
        .PAGE_W     (PW),
        .MAX_PROBES (MP)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .obs_valid  (obs_valid),
        .obs_page   (obs_page),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .meta_req   (meta_req),
        .meta_frame (meta_frame),
        .meta_page  (meta_page),
        .meta_cold  (meta_cold),
        .vic_valid  (vic_valid),
        .vic_frame  (vic_frame)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R7 hashes for a 12-bit page and a 1024-bit filter
    function automatic logic [9:0] fold12(input logic [11:0] v);
        return v[9:0] ^ {8'd0, v[11:10]};
    endfunction

    function automatic logic [9:0] mix12(input logic [11:0] v);
        logic [11:0] s;
        s = v * 12'h9B1;
        return fold12(s);
    endfunction

    function automatic bit m_hit(input logic [11:0] p);
        return mb[fold12(p)] && mb[mix12(p)];
    endfunction

    task automatic m_insert(input logic [11:0] p);
        if (mcnt == 127) begin
            mb   = '0;
            mcnt = 0;
        end else begin
            mb[fold12(p)] = 1'b1;
            mb[mix12(p)]  = 1'b1;
            mcnt++;
        end
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        obs_valid = 1'b0;
        obs_page  = '0;
        req_valid = 1'b0;
        ms        = 3'd1;
        mb        = '0;
        mcnt      = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic insert(input logic [11:0] p);
        obs_valid = 1'b1;
        obs_page  = p;
        @(negedge clk);
        obs_valid = 1'b0;
        m_insert(p);
    endtask

    // Issue one request and compare every candidate, the victim and its timing.
    task automatic request(input string tag);
        int exp_seq [0:MP-1];
        int nexp;
        int f;
        bit ok;
        nexp = 0;
        for (int k = 0; k < MP; k++) begin
            f  = (int'(ms) - 1) % NF;
            ms = {ms[1:0], ms[2] ^ ms[1]};
            exp_seq[k] = f;
            nexp = k + 1;
            ok = cold[f] && !m_hit(pg[f]);
            if (ok) break;
        end
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < nexp; k++) begin
            chk(meta_req && int'(meta_frame) == exp_seq[k], "R3 candidate order",
                int'(meta_frame), exp_seq[k]);
            chk(!vic_valid && !req_ready, "R2 busy during search (R4 lookup)",
                int'(vic_valid), 0);
            @(negedge clk);
        end
        chk(vic_valid && int'(vic_frame) == exp_seq[nexp-1], tag,
            vic_valid ? int'(vic_frame) : -1, exp_seq[nexp-1]);
        chk(req_ready && !meta_req, "R2 ready with result", int'(req_ready), 1);
        @(negedge clk);
        chk(!vic_valid, "R10 single-cycle pulse", int'(vic_valid), 0);
    endtask

    initial begin
        for (int f = 0; f < 8; f++) pg[f] = 12'(f * 37 + 5);
        cold = 8'h00;
        do_reset();

        // R1: reset state
        chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
        chk(vic_valid == 1'b0, "R1 vic_valid", int'(vic_valid), 0);
        chk(meta_req == 1'b0, "R1 meta_req", int'(meta_req), 0);

        // R5 / R9: sweep all cold/hot patterns with an empty filter
        for (int m = 0; m < 128; m++) begin
            cold = 8'(m);
            request(m == 0 ? "R9 fallback to last candidate" : "R5 first cold candidate");
        end

        // R6 / R7: sweep protected subsets, filter state carried and cleared (R8)
        do_reset();
        for (int m = 0; m < 128; m++) begin
            for (int f = 0; f < NF; f++) begin
                if (m[f]) insert(pg[f]);
            end
            cold = 8'((m * 5 + 3) & 127);
            request("R6 protected pages skipped (R7 hashes)");
        end

        // R8: 127 insertions keep every frame protected, the 128th clears
        do_reset();
        cold = 8'h7F;
        for (int f = 0; f < NF; f++) insert(pg[f]);
        for (int i = 0; i < 120; i++) insert(12'(12'h800 + i));
        request("R8 filter held below the limit (R9)");
        insert(12'hF00);
        request("R8 filter cleared at the limit");
        chk(mcnt == 0 && mb == '0, "R8 model cleared", mcnt, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule